// File: doc/BRIEF.md
# Two-Point ADC Code Corrector

This block takes raw 12-bit converter codes and straightens out the offset and gain errors of the converter. A gain coefficient and an offset coefficient, both signed 16.16 fixed-point words, are held in the block. Each accepted code is scaled by the gain, then the offset is added. The full 32-bit fixed-point result comes out, together with a 12-bit code that is rounded to the nearest integer and clamped to the converter's range.

The coefficients are written through a simple load port. The gain is taken as a full 32-bit word. The offset is taken as a stored 28-bit quantity, and the block widens it to 32 bits by copying its sign bit. A new coefficient applies from the next accepted sample onward, so a stream never sees a half-updated pair.

While calibration points are being measured, typically near 20% and 80% of full scale (ideal codes 819 and 3276), software raises an averaging mode. The block then sums blocks of 256 raw samples and reports their mean. This cuts the noise by a factor of 16. The normal corrected stream keeps running during averaging.

Top module: `adc_gain_offset_corr`

## Requirements
- R1: After reset the gain is 0x00010000 (1.0) and the offset is 0. A gain load replaces all 32 bits of the gain with `coef_data`.
- R2: For each accepted raw code c, `out_fixed` equals (gain × c + offset) modulo 2^32. The integer part sits in bits 31..16 (the code field in bits 27..16) and the fraction in bits 15..0. Example: gain 0x0000FD37, stored offset 0x0FD30000 and c = 0x82B give integer part 0x07E7 and `out_code` 2023.
- R3: `out_valid` rises in the second cycle after the clock edge that accepts a sample. The block produces exactly one result per accepted sample, in acceptance order.
- R4: When the signed integer part is 0 or more and below 4095, `out_code` is that integer plus fraction bit 15.
- R5: `out_code` is 0 when the result is negative (bit 31 set). It is 4095 when the signed integer part is 4095 or more.
- R6: An offset load uses `coef_data[27:0]` and ignores bits 31..28. If bit 27 is set, the offset's bits 31..28 become ones; otherwise they become zeros.
- R7: With `avg_mode` high, the accept of every 256th sample (counted since `avg_mode` rose or since the last average) makes `avg_valid` high for one cycle after that edge. `avg_code` is then the sum of those 256 codes shifted right by 8.
- R8: A cycle with `avg_mode` low discards any partial sum and sample count.
- R9: While `rst` is high, `in_ready`, `out_valid` and `avg_valid` are low. Once reset is released, `in_ready` is high.
- R10: A coefficient load in the same cycle as an accepted sample does not affect that sample. It applies from the next accepted sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_load_gain | input | 1 | Write `coef_data` into the gain coefficient |
| coef_load_offset | input | 1 | Write sign-extended `coef_data[27:0]` into the offset coefficient |
| coef_data | input | 32 | Coefficient value for a load |
| in_valid | input | 1 | Raw sample present |
| in_ready | output | 1 | Block can take a sample |
| in_code | input | 12 | Raw converter code |
| avg_mode | input | 1 | Enable the 256-sample averaging of raw codes |
| out_valid | output | 1 | Corrected result present for one cycle |
| out_fixed | output | 32 | Corrected value, 16.16 fixed point |
| out_code | output | 12 | Corrected value, rounded and clamped |
| avg_valid | output | 1 | Average present for one cycle |
| avg_code | output | 12 | Mean of the last 256 raw codes |

## Verification
Four properties are checked on every cycle:
- results appear exactly two cycles after an accept, and never without one;
- the rounded code agrees with the fixed-point word in both the in-range and the clamped regions;
- the average flag is a single-cycle pulse tied to an accepted sample in averaging mode;
- reset silences both outputs.

Only the bench's scenarios can show the arithmetic values, the sign extension of the stored offset, the exact moment a new coefficient takes hold, and that dropping averaging mode discards a partial sum. A scoreboard holds the expected result for each sample and the expected mean for each block of 256.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    localparam int RAW_W      = 12;
    localparam int COEF_W     = 32;
    localparam int FRAC_W     = 16;
    localparam int STORED_MSB = 27;
    localparam int AVG_LOG2   = 8;
    localparam int ACC_W      = RAW_W + AVG_LOG2;
    localparam int INT_W      = COEF_W - FRAC_W;

    typedef logic [COEF_W-1:0] coef_t;
    typedef logic [RAW_W-1:0]  code_t;

    localparam coef_t GAIN_UNITY = coef_t'(1) << FRAC_W;

    typedef struct packed {
        logic  vld;
        coef_t prod;
        coef_t off;
    } mac_stage_t;

    typedef struct packed {
        logic  vld;
        coef_t fixed;
        code_t code;
    } corr_result_t;

    // Widen a stored offset by copying its sign bit over the upper bits.
    function automatic coef_t widen_stored(input coef_t s);
        coef_t r;
        r = s;
        for (int i = STORED_MSB + 1; i < COEF_W; i++) begin
            r[i] = s[STORED_MSB];
        end
        return r;
    endfunction

    // Round to nearest on the top fraction bit, then clamp to the code range.
    function automatic code_t round_clamp(input coef_t v);
        logic signed [INT_W:0] ip;
        ip = $signed({v[COEF_W-1], v[COEF_W-1:FRAC_W]})
           + $signed({{INT_W{1'b0}}, v[FRAC_W-1]});
        if (ip < 0) begin
            return '0;
        end else if (ip > $signed({{(INT_W+1-RAW_W){1'b0}}, {RAW_W{1'b1}}})) begin
            return '1;
        end else begin
            return ip[RAW_W-1:0];
        end
    endfunction

endpackage

// File: rtl/adc_coef_regs.sv
module adc_coef_regs
    import adc_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_gain,
    input  logic  ld_off,
    input  coef_t data,
    output coef_t gain_q,
    output coef_t off_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= GAIN_UNITY;
            off_q  <= '0;
        end else begin
            if (ld_gain) gain_q <= data;
            if (ld_off)  off_q  <= widen_stored(data);
        end
    end

endmodule

// File: rtl/adc_mac_pipe.sv
module adc_mac_pipe
    import adc_cal_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         accept,
    input  code_t        code,
    input  coef_t        gain,
    input  coef_t        off,
    output corr_result_t res
);

    localparam int FULL_W = COEF_W + RAW_W;

    logic [FULL_W-1:0] full_prod;
    mac_stage_t        s1;
    coef_t             sum;

    assign full_prod = {{RAW_W{1'b0}}, gain} * {{COEF_W{1'b0}}, code};
    assign sum       = s1.prod + s1.off;

    // Stage 1: multiply with the coefficients current at the accepting edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld <= accept;
            if (accept) begin
                s1.prod <= full_prod[COEF_W-1:0];
                s1.off  <= off;
            end
        end
    end

    // Stage 2: add the offset, round and clamp.
    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.vld <= s1.vld;
            if (s1.vld) begin
                res.fixed <= sum;
                res.code  <= round_clamp(sum);
            end
        end
    end

endmodule

// File: rtl/adc_avg_acc.sv
module adc_avg_acc
    import adc_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mode,
    input  logic  accept,
    input  code_t code,
    output logic  avg_vld,
    output code_t avg
);

    logic [ACC_W-1:0]    acc;
    logic [AVG_LOG2-1:0] cnt;
    logic [ACC_W-1:0]    acc_next;

    assign acc_next = acc + {{AVG_LOG2{1'b0}}, code};

    always_ff @(posedge clk) begin
        if (rst || !mode) begin
            acc     <= '0;
            cnt     <= '0;
            avg_vld <= 1'b0;
            if (rst) avg <= '0;
        end else if (accept) begin
            if (&cnt) begin
                avg_vld <= 1'b1;
                avg     <= acc_next[ACC_W-1:AVG_LOG2];
                acc     <= '0;
                cnt     <= '0;
            end else begin
                avg_vld <= 1'b0;
                acc     <= acc_next;
                cnt     <= cnt + 1'b1;
            end
        end else begin
            avg_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_gain_offset_corr.sv
module adc_gain_offset_corr
    import adc_cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        coef_load_gain,
    input  logic        coef_load_offset,
    input  logic [31:0] coef_data,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [11:0] in_code,
    input  logic        avg_mode,
    output logic        out_valid,
    output logic [31:0] out_fixed,
    output logic [11:0] out_code,
    output logic        avg_valid,
    output logic [11:0] avg_code
);

    coef_t        gain_q;
    coef_t        off_q;
    corr_result_t res;
    logic         accept;

    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;

    adc_coef_regs u_coef (
        .clk    (clk),
        .rst    (rst),
        .ld_gain(coef_load_gain),
        .ld_off (coef_load_offset),
        .data   (coef_data),
        .gain_q (gain_q),
        .off_q  (off_q)
    );

    adc_mac_pipe u_mac (
        .clk   (clk),
        .rst   (rst),
        .accept(accept),
        .code  (in_code),
        .gain  (gain_q),
        .off   (off_q),
        .res   (res)
    );

    adc_avg_acc u_avg (
        .clk    (clk),
        .rst    (rst),
        .mode   (avg_mode),
        .accept (accept),
        .code   (in_code),
        .avg_vld(avg_valid),
        .avg    (avg_code)
    );

    assign out_valid = res.vld;
    assign out_fixed = res.fixed;
    assign out_code  = res.code;

endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        avg_mode,
    input logic        out_valid,
    input logic [31:0] out_fixed,
    input logic [11:0] out_code,
    input logic        avg_valid
);

    logic acc_ev;
    assign acc_ev = in_valid && in_ready;

    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        acc_ev |-> ##2 out_valid);

    p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(acc_ev, 2));

    p_round_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_fixed[31] && (out_fixed[31:16] < 16'd4095))
        |-> (out_code == 12'(out_fixed[27:16] + {11'b0, out_fixed[15]})));

    p_clamp_low_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fixed[31]) |-> (out_code == 12'd0));

    p_clamp_high_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_fixed[31] && (out_fixed[31:16] >= 16'd4095))
        |-> (out_code == 12'd4095));

    p_avg_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        avg_valid |=> !avg_valid);

    p_avg_source_r7: assert property (@(posedge clk) disable iff (rst)
        avg_valid |-> $past(avg_mode && acc_ev));

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && !avg_valid));

endmodule

bind adc_gain_offset_corr adc_corr_chk u_chk (.*);

// File: tb/adc_gain_offset_corr_tb.sv
module adc_gain_offset_corr_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        coef_load_gain = 1'b0;
    logic        coef_load_offset = 1'b0;
    logic [31:0] coef_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_code = '0;
    logic        avg_mode = 1'b0;
    logic        out_valid;
    logic [31:0] out_fixed;
    logic [11:0] out_code;
    logic        avg_valid;
    logic [11:0] avg_code;

    always #10 clk = ~clk;

    adc_gain_offset_corr u_dut (
        .clk(clk), .rst(rst),
        .coef_load_gain(coef_load_gain), .coef_load_offset(coef_load_offset),
        .coef_data(coef_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
        .avg_mode(avg_mode),
        .out_valid(out_valid), .out_fixed(out_fixed), .out_code(out_code),
        .avg_valid(avg_valid), .avg_code(avg_code)
    );

    typedef struct {
        logic [31:0] fx;
        logic [11:0] cd;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [11:0] avg_sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    logic [31:0] m_gain = 32'h0001_0000;
    logic [31:0] m_off  = 32'h0;
    int          m_acc  = 0;
    int          m_cnt  = 0;

    function automatic logic [31:0] mdl_fixed(logic [31:0] g, logic [31:0] o, logic [11:0] c);
        logic [63:0] p;
        p = {32'b0, g} * {52'b0, c};
        return p[31:0] + o;
    endfunction

    function automatic logic [11:0] mdl_code(logic [31:0] f);
        int ip;
        ip = int'($signed(f[31:16])) + (f[15] ? 1 : 0);
        if (ip < 0) return 12'd0;
        if (ip > 4095) return 12'd4095;
        return ip[11:0];
    endfunction

    function automatic logic [31:0] mdl_widen(logic [31:0] s);
        if (s[27]) return s | 32'hF000_0000;
        return s & 32'h0FFF_FFFF;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: one clock with optional sample and optional coefficient loads.
    task automatic step(bit v, logic [11:0] c, bit lg, bit lo, logic [31:0] d, string req);
        exp_t e;
        in_valid = v; in_code = c;
        coef_load_gain = lg; coef_load_offset = lo; coef_data = d;
        if (v) begin
            e.fx  = mdl_fixed(m_gain, m_off, c);
            e.cd  = mdl_code(e.fx);
            e.req = req;
            sb.push_back(e);
            if (avg_mode) begin
                m_acc += int'(c);
                m_cnt++;
                if (m_cnt == 256) begin
                    avg_sb.push_back(12'(m_acc >> 8));
                    m_acc = 0; m_cnt = 0;
                end
            end
        end
        if (!avg_mode) begin m_acc = 0; m_cnt = 0; end
        @(posedge clk);
        if (lg) m_gain = d;
        if (lo) m_off  = mdl_widen(d);
        @(negedge clk);
        in_valid = 1'b0; coef_load_gain = 1'b0; coef_load_offset = 1'b0;
    endtask

    task automatic sample(logic [11:0] c, string req);
        step(1'b1, c, 1'b0, 1'b0, 32'h0, req);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 12'h0, 1'b0, 1'b0, 32'h0, "");
    endtask

    task automatic set_gain(logic [31:0] g);
        step(1'b0, 12'h0, 1'b1, 1'b0, g, "");
    endtask

    task automatic set_off(logic [31:0] o);
        step(1'b0, 12'h0, 1'b0, 1'b1, o, "");
    endtask

    // Monitor: compares each result with the head of the scoreboard.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3", "unexpected result", out_fixed, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_fixed == e.fx, e.req, "out_fixed", out_fixed, e.fx);
                check(out_code == e.cd, e.req, "out_code", {20'b0, out_code}, {20'b0, e.cd});
            end
        end
        if (!rst && avg_valid) begin
            if (avg_sb.size() == 0) begin
                check(1'b0, "R7", "unexpected average", {20'b0, avg_code}, 32'h0);
            end else begin
                logic [11:0] ea;
                ea = avg_sb.pop_front();
                check(avg_code == ea, "R7", "avg_code", {20'b0, avg_code}, {20'b0, ea});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: quiet outputs during reset
        check(!in_ready, "R9", "in_ready in reset", {31'b0, in_ready}, 32'h0);
        check(!out_valid && !avg_valid, "R9", "valids in reset", {30'b0, out_valid, avg_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready, "R9", "in_ready after reset", {31'b0, in_ready}, 32'h1);

        // R1: default coefficients give identity
        sample(12'd1234, "R1");
        // R3: nothing yet one cycle after the accepting edge, result the next
        check(!out_valid, "R3", "valid too early", {31'b0, out_valid}, 32'h0);
        idle(1);
        idle(2);

        // R2 / R6: worked example with stored offset 0x0FD30000
        set_gain(32'h0000_FD37);
        set_off(32'h0FD3_0000);
        sample(12'h82B, "R2");
        idle(3);
        check(m_off == 32'hFFD3_0000, "R6", "bench offset", m_off, 32'hFFD3_0000);

        // R6: upper stored bits ignored, both signs
        set_gain(32'h0001_0000);
        set_off(32'hA000_0100);
        sample(12'd100, "R6");
        set_off(32'h5FF6_0000);
        sample(12'd100, "R6");
        idle(3);

        // R4: rounding on fraction bit 15
        set_off(32'h0);
        set_gain(32'h0001_8000);
        sample(12'd3, "R4");
        sample(12'd2, "R4");
        sample(12'd2731, "R4");
        idle(3);

        // R5: clamp high and low
        set_gain(32'h0002_0000);
        sample(12'd3000, "R5");
        set_gain(32'h0001_0000);
        set_off(32'h0F9C_0000);
        sample(12'd50, "R5");
        sample(12'd4095, "R5");
        idle(3);

        // R10: load in the same cycle as a sample affects only later samples
        set_off(32'h0);
        step(1'b1, 12'd1000, 1'b1, 1'b0, 32'h0000_8000, "R10");
        sample(12'd1000, "R10");
        step(1'b1, 12'd400, 1'b0, 1'b1, 32'h0005_0000, "R10");
        sample(12'd400, "R10");
        idle(3);

        // R1: gain load replaces the full word; R3 back-to-back stream ordering
        set_gain(32'h0001_0000);
        set_off(32'h0);
        for (int i = 0; i < 20; i++) sample(12'(i * 197 + 5), "R3");
        idle(3);

        // R7: average of 256 varied codes
        avg_mode = 1'b1;
        for (int i = 0; i < 256; i++) sample(12'((i * 37 + 11) % 4096), "R7");
        idle(2);
        for (int i = 0; i < 256; i++) sample(12'(819 + (i % 5)), "R7");
        idle(2);

        // R8: a cycle with avg_mode low discards a partial sum
        for (int i = 0; i < 100; i++) sample(12'd4000, "R8");
        avg_mode = 1'b0;
        idle(1);
        avg_mode = 1'b1;
        for (int i = 0; i < 256; i++) sample(12'd3276, "R8");
        idle(2);
        check(avg_code == 12'd3276, "R8", "average after clear", {20'b0, avg_code}, 32'd3276);
        avg_mode = 1'b0;
        idle(4);

        check(sb.size() == 0, "R3", "results outstanding", sb.size(), 32'h0);
        check(avg_sb.size() == 0, "R7", "averages outstanding", avg_sb.size(), 32'h0);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule